// File: doc/BRIEF.md
# Key Matrix Scan Port

This block is a byte-wide, memory-mapped input port that scans eight keys wired as two groups of four. Software writes a two-bit group-select field into the port. Every read returns that field together with the state of the chosen keys on the low four bits. A pressed key reads as 0, and the two top bits always read as 1.

The raw key vector comes in already synchronised and debounced. In that vector, bits 3:0 form the low group, bits 7:4 form the high group, and a 1 means the key is held down. A select bit at 0 enables a group:

- Bit 5 at 0 enables the low group.
- Bit 4 at 0 enables the high group.
- With both bits at 0, the two groups are merged with a bitwise OR.
- With both bits at 1, no key is reported.

Reads are purely combinational, so a change on the keys shows on the read bus in the same cycle. A write takes effect at the next rising clock edge.

Top module: `key_matrix_port`

## Requirements
- R1: After reset the select field is 2'b11, and the read bus returns 8'hFF while all keys are up or down.
- R2: A write (cpuSel and cpuWr high at a rising edge) stores only cpuWrData[5:4]. All other written bits are discarded and never appear on the read bus.
- R3: With select 2'b11, read bits 3:0 are 4'b1111 whatever the key vector holds.
- R4: With select 2'b10, read bits 3:0 are the inverse of keyDown[7:4].
- R5: With select 2'b01, read bits 3:0 are the inverse of keyDown[3:0].
- R6: With select 2'b00, read bit i (i = 0..3) is 0 when keyDown[i] or keyDown[i+4] is 1.
- R7: Read bits 7:6 are always 2'b11.
- R8: Read bits 5:4 always show the stored select field.
- R9: A change on keyDown appears on cpuRdData in the same cycle, before any clock edge.
- R10: A write cycle with cpuSel low leaves the select field unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuSel | input | 1 | Port selected by the CPU address decode |
| cpuWr | input | 1 | Write enable, qualified by cpuSel |
| cpuWrData | input | 8 | Write data; only bits 5:4 are kept |
| cpuRdData | output | 8 | Combinational read data |
| keyDown | input | 8 | Raw key vector, 1 = pressed, bits 3:0 low group |

## Verification
The bench drives several key patterns under all four select codes:

- **Only the high group pressed, and only the low group pressed.** These tell the 2'b10 and 2'b01 codes apart and would expose swapped groups.
- **Disjoint bits in each group, and overlapping bits.** These show the 2'b00 merge as an OR rather than an AND or a single-group pick.
- **All keys down.** This proves that 2'b11 masks every key.

Writes carry junk in the bits outside the select field, and one write is issued with cpuSel low, to show that both are discarded. Key changes are checked between clock edges to confirm the read has no latency.

// File: rtl/key_matrix_pkg.sv
package key_matrix_pkg;
  localparam int DATA_W   = 8;
  localparam int GROUP_W  = 4;
  localparam int GROUPS   = 2;
  localparam int SEL_LSB  = 4;
  localparam int SEL_W    = GROUPS;
  localparam int SEL_MSB  = SEL_LSB + SEL_W - 1;
  localparam int KEYS_W   = GROUP_W * GROUPS;

  typedef struct packed {
    logic             wrSel;
    logic [SEL_W-1:0] selVal;
  } ctrlStrobe_t;
endpackage

// File: rtl/key_matrix_ctrl.sv
module key_matrix_ctrl
  import key_matrix_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuSel,
  input  logic              cpuWr,
  input  logic [DATA_W-1:0] cpuWrData,
  output ctrlStrobe_t       strobe
);
  logic unusedBits;

  always_comb begin
    strobe.wrSel  = cpuSel & cpuWr;
    strobe.selVal = cpuWrData[SEL_MSB:SEL_LSB];
  end

  assign unusedBits = ^{cpuWrData[DATA_W-1:SEL_MSB+1], cpuWrData[SEL_LSB-1:0]};

  // R10: no write strobe without the port being selected
  a_r10_no_stray_write: assert property (@(posedge clk) disable iff (!rstN)
    !cpuSel |-> !strobe.wrSel);
endmodule

// File: rtl/key_matrix_datapath.sv
module key_matrix_datapath
  import key_matrix_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [KEYS_W-1:0] keyDown,
  output logic [DATA_W-1:0] rdData
);
  logic [SEL_W-1:0]   selReg;
  logic [GROUP_W-1:0] groupHit [GROUPS];
  logic [GROUP_W-1:0] merged;

  always_ff @(posedge clk) begin
    if (!rstN)              selReg <= '1;
    else if (strobe.wrSel)  selReg <= strobe.selVal;
  end

  // Group g is enabled when select bit (GROUPS-1-g) is low.
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign groupHit[g] = selReg[GROUPS-1-g] ? '0 : keyDown[g*GROUP_W +: GROUP_W];
  end

  always_comb begin
    merged = '0;
    for (int g = 0; g < GROUPS; g++) merged = merged | groupHit[g];
  end

  assign rdData = {{(DATA_W-SEL_MSB-1){1'b1}}, selReg, ~merged};

  a_r7_top_ones: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:SEL_MSB+1] == '1);
  a_r3_none_reported: assert property (@(posedge clk) disable iff (!rstN)
    rdData[SEL_MSB:SEL_LSB] == '1 |-> rdData[GROUP_W-1:0] == '1);
  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrSel |=> $stable(rdData[SEL_MSB:SEL_LSB]));
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrSel |=> rdData[SEL_MSB:SEL_LSB] == $past(strobe.selVal));
endmodule

// File: rtl/key_matrix_port.sv
module key_matrix_port
  import key_matrix_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuSel,
  input  logic        cpuWr,
  input  logic [7:0]  cpuWrData,
  output logic [7:0]  cpuRdData,
  input  logic [7:0]  keyDown
);
  ctrlStrobe_t strobe;

  key_matrix_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr),
    .cpuWrData(cpuWrData), .strobe(strobe)
  );

  key_matrix_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .keyDown(keyDown),
    .rdData(cpuRdData)
  );
endmodule

// File: tb/key_matrix_port_tb.sv
`timescale 1ns/1ps
module key_matrix_port_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuSel = 1'b0;
  logic       cpuWr = 1'b0;
  logic [7:0] cpuWrData = 8'h00;
  logic [7:0] keyDown = 8'h00;
  logic [7:0] cpuRdData;

  int checks = 0;
  int fails  = 0;
  int selModel = 3;
  bit running = 1'b1;

  always #2.5 clk = ~clk;

  key_matrix_port u_dut (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData), .keyDown(keyDown)
  );

  function automatic logic [7:0] expRead(int sel, logic [7:0] k);
    logic [3:0] hit;
    case (sel)
      3:       hit = 4'h0;
      2:       hit = k[7:4];
      1:       hit = k[3:0];
      default: hit = k[7:4] | k[3:0];
    endcase
    return {2'b11, 2'(sel), ~hit};
  endfunction

  function automatic string selTag(int sel);
    case (sel)
      3: return "R3";
      2: return "R4";
      1: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // Reference model of the select field
  always @(posedge clk) begin
    if (!rstN) selModel = 3;
    else if (cpuSel && cpuWr) selModel = int'(cpuWrData[5:4]);
  end

  // Per-cycle comparison (covers R7 and R8 as well)
  always @(negedge clk) begin
    if (rstN && running) check({selTag(selModel), "/R7/R8"}, cpuRdData, expRead(selModel, keyDown));
  end

  task automatic wrSel(logic [7:0] d, logic sel);
    @(negedge clk); #0.5;
    cpuSel = sel; cpuWr = 1'b1; cpuWrData = d;
    @(negedge clk); #0.5;
    cpuSel = 1'b0; cpuWr = 1'b0; cpuWrData = 8'h00;
  endtask

  task automatic keys(logic [7:0] k);
    @(negedge clk); #0.5;
    keyDown = k;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] pats [5] = '{8'hA0, 8'h05, 8'h81, 8'h33, 8'hFF};
    keyDown = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #0.5;
    check("R1", cpuRdData, 8'hFF);
    keyDown = 8'h00; #0.5;
    check("R1", cpuRdData, 8'hFF);
    // R3..R6: every select code against several patterns; junk bits for R2
    for (int s = 0; s < 4; s++) begin
      wrSel({2'b01, 2'(s), 4'hA} ^ 8'hC5 & 8'hCF, 1'b1);
      check("R2", cpuRdData, expRead(s, keyDown));
      foreach (pats[i]) keys(pats[i]);
    end
    // R10: unselected write ignored
    wrSel(8'h30, 1'b1);
    keys(8'h5A);
    wrSel(8'h00, 1'b0);
    check("R10", cpuRdData, expRead(3, 8'h5A));
    // R9: same-cycle key reflection
    wrSel(8'h00, 1'b1);
    @(negedge clk); #0.5;
    keyDown = 8'h10; #0.5;
    check("R9", cpuRdData, 8'hCE);
    keyDown = 8'h02; #0.5;
    check("R9", cpuRdData, 8'hCD);
    // R2: all junk bits set around select 01
    wrSel(8'hDF, 1'b1);
    check("R2", cpuRdData, expRead(1, keyDown));
    keys(8'hF0);
    check("R5", cpuRdData, 8'hDF);
    running = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule